// File: doc/BRIEF.md
# Upstream Grant Count Chain Stage

This block sits in an upstream node of a mesh row or column and handles that node's part in a counted-grant handshake with downstream targets. Each target drives a one-bit availability line. When the node has a flit waiting for a target that advertised in the previous cycle, it drives that target's request line for one cycle. The target counts the requests on its line. It then sends back a count of the grants it made, and that count travels from node to node toward the upstream end of the chain.

As the count passes through this stage, a node with a pending request takes one grant if the count is non-zero. It passes the count on reduced by one and sends a one-cycle grant pulse to its local switch allocator. A node without a pending request passes the count on unchanged. A zero count means the request was denied, and the node tries again at the next advertisement. Every target has its own count path through the stage, and each path is delayed by one register.

Top module: `grant_chain_stage`

## Requirements
- R1: A request for target t is driven (req_out[t]=1) exactly one cycle after a cycle in which adv_in[t]=1, flit_valid=1, flit_tgt=t, flit_drop=0 and no request was pending. In no other case is a request driven.
- R2: At most one bit of req_out is set in any cycle.
- R3: A count that arrives (cnt_vld_in[i]=1, value in cnt_in bits [i*CNT_W +: CNT_W]) on a path where the node has no pending request leaves on cnt_out with the same value, with cnt_vld_out[i]=1, one cycle later.
- R4: When a count arrives on the pending target's path with a non-zero value, the next cycle shows that value minus one on the path and grant_out=1, and the request is no longer pending.
- R5: When a count of zero arrives on the pending target's path, zero is forwarded and grant_out stays 0. The request is cleared, and a new request follows the target's next advertisement.
- R6: While a request is pending, no new request is driven, even if an advertisement is seen.
- R7: flit_drop=1 cancels a pending request (and any request in that cycle). Counts that arrive in that cycle or later pass unchanged, with no grant.
- R8: grant_out is never high for two cycles in a row and is only raised for a pending request.
- R9: After reset, req_out, grant_out, cnt_out and cnt_vld_out are all zero. A path with cnt_vld_in=0 shows cnt_vld_out=0 and a count of zero one cycle later.
- R10: Counts on the paths of other targets pass unchanged while a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid | input | 1 | A local flit waits for a downstream buffer |
| flit_tgt | input | TGT_W | Target index chosen for the waiting flit |
| flit_drop | input | 1 | Flit gives up its current target |
| adv_in | input | N_TGT | Availability bit sensed on each target's line |
| req_out | output | N_TGT | Request driven on each target's line |
| cnt_vld_in | input | N_TGT | Granted count present, per target path |
| cnt_in | input | N_TGT*CNT_W | Granted counts from downstream, packed by target |
| cnt_vld_out | output | N_TGT | Forwarded count present, per target path |
| cnt_out | output | N_TGT*CNT_W | Forwarded counts toward upstream |
| grant_out | output | 1 | One-cycle grant to the local switch allocator |

## Verification
Directed sequences cover the following cases, one at a time:
- a clean request followed by a non-zero count (decrement plus grant);
- a zero count followed by a retry (denial without grant);
- an advertisement while a request is pending (no second request);
- a drop before the count arrives (pass-through);
- a count on a foreign path (isolation between paths).

Random stimulus then mixes advertisements, target changes, drops and counts of every value. This exposes ordering faults such as a count and a drop landing in the same cycle, or a count arriving in the same cycle as the request. A reference model in the bench tracks the pending state and predicts every output one cycle ahead.

// File: rtl/grant_chain_stage.sv
`timescale 1ns/1ps
module grant_chain_stage #(
  parameter int N_TGT = 4,
  parameter int CNT_W = 3,
  parameter int TGT_W = $clog2(N_TGT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flit_valid,
  input  logic [TGT_W-1:0]       flit_tgt,
  input  logic                   flit_drop,
  input  logic [N_TGT-1:0]       adv_in,
  output logic [N_TGT-1:0]       req_out,
  input  logic [N_TGT-1:0]       cnt_vld_in,
  input  logic [N_TGT*CNT_W-1:0] cnt_in,
  output logic [N_TGT-1:0]       cnt_vld_out,
  output logic [N_TGT*CNT_W-1:0] cnt_out,
  output logic                   grant_out
);

  logic             pend;
  logic [TGT_W-1:0] pend_tgt;

  wire             here  = cnt_vld_in[pend_tgt];
  wire [CNT_W-1:0] avail = cnt_in[pend_tgt*CNT_W +: CNT_W];
  wire             take  = pend && !flit_drop && here && (avail != '0);
  wire             issue = !pend && flit_valid && !flit_drop && adv_in[flit_tgt];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_tgt  <= '0;
      req_out   <= '0;
      grant_out <= 1'b0;
    end else begin
      pend      <= pend ? !(flit_drop || here) : issue;
      if (issue) pend_tgt <= flit_tgt;
      req_out   <= issue ? (N_TGT'(1) << flit_tgt) : '0;
      grant_out <= take;
    end
  end

  for (genvar i = 0; i < N_TGT; i++) begin : g_path
    wire mine = take && (pend_tgt == TGT_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_vld_out[i]                 <= 1'b0;
        cnt_out[i*CNT_W +: CNT_W]      <= '0;
      end else begin
        cnt_vld_out[i]                 <= cnt_vld_in[i];
        cnt_out[i*CNT_W +: CNT_W]      <= cnt_vld_in[i]
                                          ? cnt_in[i*CNT_W +: CNT_W] - CNT_W'(mine)
                                          : '0;
      end
    end

    AST_REQ_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      req_out[i] |-> $past(adv_in[i]));  // R1

    AST_PASS_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_vld_in[i] && !(pend && pend_tgt == TGT_W'(i)))
      |=> (cnt_out[i*CNT_W +: CNT_W] == $past(cnt_in[i*CNT_W +: CNT_W])));  // R3
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_out));  // R2

  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> (req_out == '0));  // R6

  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_out |=> !grant_out);  // R8

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    grant_out |-> $past(pend));  // R8

endmodule

// File: tb/test_grant_chain_stage.sv
`timescale 1ns/1ps
module test_grant_chain_stage;
  localparam int N  = 4;
  localparam int CW = 3;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flit_valid, flit_drop;
  logic [TW-1:0] flit_tgt;
  logic [N-1:0]  adv_in, req_out, cnt_vld_in, cnt_vld_out;
  logic [N*CW-1:0] cnt_in, cnt_out;
  logic          grant_out;

  grant_chain_stage #(.N_TGT(N), .CNT_W(CW), .TGT_W(TW)) i_grant_chain_stage (
    .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_tgt(flit_tgt),
    .flit_drop(flit_drop), .adv_in(adv_in), .req_out(req_out),
    .cnt_vld_in(cnt_vld_in), .cnt_in(cnt_in), .cnt_vld_out(cnt_vld_out),
    .cnt_out(cnt_out), .grant_out(grant_out));

  always #2.5 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  bit          m_pend;
  int          m_tgt;
  logic [N-1:0]    e_req, e_vld;
  logic [N*CW-1:0] e_cnt;
  logic            e_gnt;

  function automatic logic [N-1:0] f_req(input logic [N-1:0] adv, input bit fv,
                                         input int tg, input bit dr);
    logic [N-1:0] r = '0;
    if (!m_pend && fv && !dr && adv[tg]) r[tg] = 1'b1;
    return r;
  endfunction

  function automatic logic [N*CW-1:0] f_cnt(input logic [N-1:0] cv,
                                            input logic [N*CW-1:0] ci, input bit dr);
    logic [N*CW-1:0] o = '0;
    for (int i = 0; i < N; i++) begin
      logic [CW-1:0] v = ci[i*CW +: CW];
      if (cv[i]) begin
        if (m_pend && !dr && i == m_tgt && v != 0) v = v - 1'b1;
        o[i*CW +: CW] = v;
      end
    end
    return o;
  endfunction

  function automatic bit f_gnt(input logic [N-1:0] cv, input logic [N*CW-1:0] ci,
                               input bit dr);
    return m_pend && !dr && cv[m_tgt] && (ci[m_tgt*CW +: CW] != 0);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] adv, input bit fv, input int tg, input bit dr,
                      input logic [N-1:0] cv, input logic [N*CW-1:0] ci, input string tag);
    adv_in = adv; flit_valid = fv; flit_tgt = TW'(tg); flit_drop = dr;
    cnt_vld_in = cv; cnt_in = ci;
    e_req = f_req(adv, fv, tg, dr);
    e_cnt = f_cnt(cv, ci, dr);
    e_gnt = f_gnt(cv, ci, dr);
    e_vld = cv;
    if (m_pend) begin
      if (dr || cv[m_tgt]) m_pend = 0;
    end else if (e_req != 0) begin
      m_pend = 1; m_tgt = tg;
    end
    @(posedge clk); @(negedge clk);
    chk(tag, "req_out",     32'(req_out),     32'(e_req));
    chk(tag, "grant_out",   32'(grant_out),   32'(e_gnt));
    chk(tag, "cnt_out",     32'(cnt_out),     32'(e_cnt));
    chk(tag, "cnt_vld_out", 32'(cnt_vld_out), 32'(e_vld));
  endtask

  function automatic logic [N*CW-1:0] at(input int t, input int v);
    logic [N*CW-1:0] o = '0;
    o[t*CW +: CW] = CW'(v);
    return o;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; flit_valid = 0; flit_tgt = 0; flit_drop = 0;
    adv_in = 0; cnt_vld_in = 0; cnt_in = 0;
    m_pend = 0; m_tgt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "req_out",     32'(req_out),     0);
    chk("R9", "grant_out",   32'(grant_out),   0);
    chk("R9", "cnt_out",     32'(cnt_out),     0);
    chk("R9", "cnt_vld_out", 32'(cnt_vld_out), 0);
    rst_n = 1;

    // R1: no advertisement for chosen target, then a clean request
    step(4'b0001, 1, 2, 0, '0, '0, "R1");
    step(4'b0100, 1, 2, 0, '0, '0, "R1 R2");
    // R6: advertisement while pending is ignored
    step(4'b0100, 1, 2, 0, '0, '0, "R6");
    // R10: foreign path passes unchanged while pending
    step('0, 1, 2, 0, 4'b0010, at(1, 5), "R10");
    // R4: non-zero count on own path
    step('0, 1, 2, 0, 4'b0100, at(2, 3), "R4 R8");
    step('0, 0, 2, 0, '0, '0, "R8 R9");
    // R5: zero count denies, retry at next advertisement
    step(4'b0100, 1, 2, 0, '0, '0, "R5");
    step('0, 1, 2, 0, 4'b0100, at(2, 0), "R5");
    step(4'b0100, 1, 2, 0, '0, '0, "R5");
    // R7: drop cancels, later count passes unchanged
    step('0, 1, 2, 1, '0, '0, "R7");
    step('0, 1, 2, 0, 4'b0100, at(2, 2), "R7");
    // R7: drop in the same cycle as the count
    step(4'b1000, 1, 3, 0, '0, '0, "R7");
    step('0, 1, 3, 1, 4'b1000, at(3, 7), "R7");
    // R3: count with no request anywhere
    step('0, 0, 0, 0, 4'b0001, at(0, 6), "R3");

    for (int k = 0; k < 3000; k++) begin
      logic [N*CW-1:0] ci;
      logic [N-1:0] cv;
      ci = N*CW'($urandom);
      cv = N'($urandom) & N'($urandom);
      step(N'($urandom), ($urandom % 4) != 0, $urandom % N, ($urandom % 10) == 0,
           cv, ci, "R1 R2 R3 R4 R5 R6 R7 R8 R10");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule